// File: doc/BRIEF.md
# Sensor Thermal Contrast Controller

This block closes a loop around the self-heater of a swept thermal image sensor. Once per frame the sensor delivers a 4-bit relative thermometer code, and the block receives it with a valid strobe. Code 8 means no change. The scale is nonlinear, and the two end codes saturate. When image processing reports low contrast, the block takes the next code as its starting point and drives the heater enable. It stops when the code has climbed a set number of steps above that start, or when a frame-counted timeout expires.

Every strobe also updates a signed temperature delta in tenths of a kelvin. A companion flag marks the two end codes, because for those the delta is only a bound. A nap input turns the heater off at once and puts the controller back in idle.

Top module: `thermal_boost_ctrl`

## Requirements
- R1: After reset, heat_en, busy, done, timeout, sat_done, delta_dk and delta_sat are all 0.
- R2: One clock after a strobe with tcode_valid=1, delta_dk holds the signed change in 0.1 K for tcode. The values are:
  - codes 2 to 14: (code-8)*14
  - code 15: +112
  - code 1: -112
  - code 0: -168

  delta_sat is 1 only for codes 0 and 15. Both outputs hold their value while no strobe arrives.
- R3: A boost_req while idle and not napping raises busy on the next clock. The first strobe that follows captures the start code. If start+STEP is at most 15, heat_en is high from the clock after that strobe.
- R4: While heating, a strobe whose code is at least start+STEP ends the cycle on the next clock: heat_en=0, busy=0, done=1, timeout=0.
- R5: If the captured start code plus STEP exceeds 15 (codes 14 and 15 with STEP=2), heating is skipped. On the next clock busy=0, heat_en=0, done=1 and sat_done=1.
- R6: While heating, if TIMEOUT_FRAMES strobes arrive without any of them reaching the target, the clock after the last one gives heat_en=0, busy=0, timeout=1, done=0. A strobe that reaches the target wins over the timeout.
- R7: While nap=1, heat_en is 0 in the same cycle with no register delay. From the next clock the controller is idle with done, timeout and sat_done cleared, and boost_req is ignored.
- R8: A boost_req while busy is ignored. done, timeout and sat_done keep their value until the next accepted request, which clears them on the next clock.
- R9: heat_en is never 1 while busy is 0, and done and timeout are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nap | input | 1 | Power-down; forces heater off and controller idle |
| tcode_valid | input | 1 | One-cycle strobe, a new temperature code is present |
| tcode | input | 4 | Relative thermometer code, 8 = no change |
| boost_req | input | 1 | Low-contrast request from image processing |
| heat_en | output | 1 | Heater enable |
| busy | output | 1 | Waiting for start code or heating |
| done | output | 1 | Last cycle reached its target or was skipped |
| timeout | output | 1 | Last cycle ended by frame timeout |
| sat_done | output | 1 | Last cycle was skipped because the start code was near saturation |
| delta_dk | output | DELTA_W | Signed temperature change in 0.1 K |
| delta_sat | output | 1 | delta_dk is a bound only (saturated code) |

## Verification
The following results come one clock after the stimulus that causes them:
- busy after an accepted request;
- delta_dk and delta_sat after a strobe;
- heat_en, done, timeout and sat_done after the strobe that starts or ends heating.

The single exception is nap, which drops heat_en within the same cycle. The bench changes inputs only on falling edges. It checks registered results at the next falling edge, so exactly one rising edge lies between stimulus and check. The nap check samples one nanosecond after nap rises, with no edge in between. Timeout is checked at the strobe just before the limit and at the limit itself, and a target reached on the limiting strobe is checked separately.

// File: rtl/tbc_pkg.sv
package tbc_pkg;

    localparam int CODE_W   = 4;
    localparam int CODE_MID = 8;
    localparam int CODE_MAX = (1 << CODE_W) - 1;
    localparam int TGT_W    = CODE_W + 1;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_HEAT = 2'd2
    } tbc_state_e;

    typedef struct packed {
        tbc_state_e         state;
        logic [TGT_W-1:0]   target;
        logic               done;
        logic               timeout;
        logic               sat_done;
    } tbc_ctrl_t;

endpackage

// File: rtl/tbc_thermo_map.sv
module tbc_thermo_map
    import tbc_pkg::*;
#(
    parameter int DELTA_W = 10,
    parameter int STEP_DK = 14
) (
    input  logic [CODE_W-1:0]        code,
    output logic signed [DELTA_W-1:0] delta,
    output logic                     sat
);

    localparam int HI_DK   = CODE_MID * STEP_DK;
    localparam int LO1_DK  = -(CODE_MID * STEP_DK);
    localparam int LO0_DK  = -((CODE_MID + CODE_MID / 2) * STEP_DK);

    int value;

    always_comb begin
        sat = (code == '0) || (code == CODE_W'(CODE_MAX));
        if (code == CODE_W'(CODE_MAX)) begin
            value = HI_DK;
        end else if (code == CODE_W'(1)) begin
            value = LO1_DK;
        end else if (code == '0) begin
            value = LO0_DK;
        end else begin
            value = (int'(code) - CODE_MID) * STEP_DK;
        end
        delta = DELTA_W'(value);
    end

endmodule

// File: rtl/tbc_frame_timer.sv
module tbc_frame_timer #(
    parameter int TIMEOUT_FRAMES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    output logic expire
);

    localparam int CNT_W = $clog2(TIMEOUT_FRAMES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_FRAMES - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d  = cnt_q;
        expire = tick && (cnt_q == LAST);
        if (clr) begin
            cnt_d = '0;
        end else if (tick && !expire) begin
            cnt_d = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/tbc_ctrl_fsm.sv
module tbc_ctrl_fsm
    import tbc_pkg::*;
#(
    parameter int STEP = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nap,
    input  logic              req,
    input  logic              tvalid,
    input  logic [CODE_W-1:0] tcode,
    input  logic              expire,
    output logic              heat_on,
    output logic              busy,
    output logic              done,
    output logic              timeout,
    output logic              sat_done,
    output logic              timer_clr,
    output logic              timer_tick
);

    localparam logic [TGT_W-1:0] STEP_T = TGT_W'(STEP);
    localparam logic [TGT_W-1:0] MAX_T  = TGT_W'(CODE_MAX);

    tbc_ctrl_t ctl_d, ctl_q;
    logic [TGT_W-1:0] code_ext;
    logic [TGT_W-1:0] goal;
    logic             reached;

    always_comb begin
        code_ext   = TGT_W'(tcode);
        goal       = code_ext + STEP_T;
        reached    = (code_ext >= ctl_q.target);
        timer_clr  = (ctl_q.state != ST_HEAT);
        timer_tick = (ctl_q.state == ST_HEAT) && tvalid && !reached;
        ctl_d      = ctl_q;

        unique case (ctl_q.state)
            ST_IDLE: begin
                if (req) begin
                    ctl_d.state    = ST_WAIT;
                    ctl_d.done     = 1'b0;
                    ctl_d.timeout  = 1'b0;
                    ctl_d.sat_done = 1'b0;
                end
            end
            ST_WAIT: begin
                if (tvalid) begin
                    if (goal > MAX_T) begin
                        ctl_d.state    = ST_IDLE;
                        ctl_d.done     = 1'b1;
                        ctl_d.sat_done = 1'b1;
                    end else begin
                        ctl_d.state  = ST_HEAT;
                        ctl_d.target = goal;
                    end
                end
            end
            ST_HEAT: begin
                if (tvalid) begin
                    if (reached) begin
                        ctl_d.state = ST_IDLE;
                        ctl_d.done  = 1'b1;
                    end else if (expire) begin
                        ctl_d.state   = ST_IDLE;
                        ctl_d.timeout = 1'b1;
                    end
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase

        if (nap) begin
            ctl_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign heat_on  = (ctl_q.state == ST_HEAT) && !nap;
    assign busy     = (ctl_q.state != ST_IDLE);
    assign done     = ctl_q.done;
    assign timeout  = ctl_q.timeout;
    assign sat_done = ctl_q.sat_done;

endmodule

// File: rtl/thermal_boost_ctrl.sv
module thermal_boost_ctrl
    import tbc_pkg::*;
#(
    parameter int DELTA_W        = 10,
    parameter int STEP_DK        = 14,
    parameter int STEP           = 2,
    parameter int TIMEOUT_FRAMES = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      nap,
    input  logic                      tcode_valid,
    input  logic [3:0]                tcode,
    input  logic                      boost_req,
    output logic                      heat_en,
    output logic                      busy,
    output logic                      done,
    output logic                      timeout,
    output logic                      sat_done,
    output logic signed [DELTA_W-1:0] delta_dk,
    output logic                      delta_sat
);

    typedef struct packed {
        logic signed [DELTA_W-1:0] dk;
        logic                      sat;
    } delta_t;

    delta_t delta_d, delta_q;

    logic signed [DELTA_W-1:0] map_dk;
    logic                      map_sat;
    logic                      t_clr, t_tick, t_expire;

    tbc_thermo_map #(
        .DELTA_W (DELTA_W),
        .STEP_DK (STEP_DK)
    ) u_map (
        .code  (tcode),
        .delta (map_dk),
        .sat   (map_sat)
    );

    tbc_frame_timer #(
        .TIMEOUT_FRAMES (TIMEOUT_FRAMES)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (t_clr),
        .tick   (t_tick),
        .expire (t_expire)
    );

    tbc_ctrl_fsm #(
        .STEP (STEP)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .nap        (nap),
        .req        (boost_req),
        .tvalid     (tcode_valid),
        .tcode      (tcode),
        .expire     (t_expire),
        .heat_on    (heat_en),
        .busy       (busy),
        .done       (done),
        .timeout    (timeout),
        .sat_done   (sat_done),
        .timer_clr  (t_clr),
        .timer_tick (t_tick)
    );

    always_comb begin
        delta_d = delta_q;
        if (tcode_valid) begin
            delta_d.dk  = map_dk;
            delta_d.sat = map_sat;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            delta_q <= '0;
        end else begin
            delta_q <= delta_d;
        end
    end

    assign delta_dk  = delta_q.dk;
    assign delta_sat = delta_q.sat;

endmodule

// File: rtl/tbc_checker.sv
module tbc_checker #(
    parameter int DELTA_W = 10
) (
    input logic               clk,
    input logic               rst_n,
    input logic               nap,
    input logic               tcode_valid,
    input logic               heat_en,
    input logic               busy,
    input logic               done,
    input logic               timeout,
    input logic               sat_done,
    input logic [DELTA_W-1:0] delta_dk,
    input logic               delta_sat
);

    assert_nap_heat_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        nap |-> !heat_en);

    assert_nap_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        nap |=> !busy && !done && !timeout);

    assert_heat_needs_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        heat_en |-> busy);

    assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && timeout));

    assert_done_stops_heat_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> !heat_en && !busy);

    assert_sat_implies_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sat_done |-> done);

    assert_timeout_after_heat_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout) |-> $past(heat_en) && $past(tcode_valid));

    assert_delta_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !tcode_valid |=> $stable(delta_dk) && $stable(delta_sat));

endmodule

bind thermal_boost_ctrl tbc_checker #(.DELTA_W(DELTA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .nap         (nap),
    .tcode_valid (tcode_valid),
    .heat_en     (heat_en),
    .busy        (busy),
    .done        (done),
    .timeout     (timeout),
    .sat_done    (sat_done),
    .delta_dk    (delta_dk),
    .delta_sat   (delta_sat)
);

// File: tb/sim_thermal_boost_ctrl.sv
module sim_thermal_boost_ctrl;

    localparam int DW = 10;
    localparam int TO = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic nap = 1'b0;
    logic tcode_valid = 1'b0;
    logic [3:0] tcode = '0;
    logic boost_req = 1'b0;
    logic heat_en, busy, done, timeout, sat_done, delta_sat;
    logic signed [DW-1:0] delta_dk;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // stimulus code, expected delta in 0.1 K, expected saturation flag
    localparam int VEC [16][3] = '{
        '{8, 0, 0},    '{15, 112, 1}, '{0, -168, 0+1}, '{9, 14, 0},
        '{1, -112, 0}, '{14, 84, 0},  '{2, -84, 0},    '{7, -14, 0},
        '{13, 70, 0},  '{3, -70, 0},  '{12, 56, 0},    '{4, -56, 0},
        '{11, 42, 0},  '{5, -42, 0},  '{10, 28, 0},    '{6, -28, 0}
    };

    thermal_boost_ctrl #(
        .DELTA_W        (DW),
        .STEP           (2),
        .TIMEOUT_FRAMES (TO)
    ) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .nap         (nap),
        .tcode_valid (tcode_valid),
        .tcode       (tcode),
        .boost_req   (boost_req),
        .heat_en     (heat_en),
        .busy        (busy),
        .done        (done),
        .timeout     (timeout),
        .sat_done    (sat_done),
        .delta_dk    (delta_dk),
        .delta_sat   (delta_sat)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic strobe(input int code);
        tcode       = 4'(code);
        tcode_valid = 1'b1;
        @(negedge clk);
        tcode_valid = 1'b0;
    endtask

    task automatic request();
        boost_req = 1'b1;
        @(negedge clk);
        boost_req = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 heat_en", int'(heat_en), 0);
        chk("R1 busy", int'(busy), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 timeout", int'(timeout), 0);
        chk("R1 sat_done", int'(sat_done), 0);
        chk("R1 delta_dk", int'(delta_dk), 0);
        chk("R1 delta_sat", int'(delta_sat), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: mapping table walk
        for (int i = 0; i < 16; i++) begin
            strobe(VEC[i][0]);
            chk($sformatf("R2 delta code %0d", VEC[i][0]), int'(delta_dk), VEC[i][1]);
            chk($sformatf("R2 sat code %0d", VEC[i][0]), int'(delta_sat), VEC[i][2]);
        end
        repeat (3) @(negedge clk);
        chk("R2 delta held", int'(delta_dk), -28);

        // R3 / R4: start 5, target 7
        request();
        chk("R3 busy after req", int'(busy), 1);
        chk("R3 no heat before start", int'(heat_en), 0);
        strobe(5);
        chk("R3 heat on", int'(heat_en), 1);
        strobe(6);
        chk("R4 still heating", int'(heat_en), 1);
        chk("R4 not done yet", int'(done), 0);
        strobe(7);
        chk("R4 heat off", int'(heat_en), 0);
        chk("R4 done", int'(done), 1);
        chk("R4 busy low", int'(busy), 0);

        // R8: done held, new request clears it, extra request ignored
        repeat (2) @(negedge clk);
        chk("R8 done held", int'(done), 1);
        request();
        chk("R8 done cleared", int'(done), 0);
        strobe(3);
        request();
        chk("R8 req while busy ignored", int'(heat_en), 1);
        strobe(4);
        chk("R8 target from first capture", int'(heat_en), 1);
        strobe(5);
        chk("R8 done at 5", int'(done), 1);

        // R5: start code 14 skips heating
        request();
        strobe(14);
        chk("R5 done", int'(done), 1);
        chk("R5 sat_done", int'(sat_done), 1);
        chk("R5 no heat", int'(heat_en), 0);
        chk("R5 busy low", int'(busy), 0);
        // boundary: start 13 heats
        request();
        chk("R8 sat_done cleared", int'(sat_done), 0);
        strobe(13);
        chk("R5 code 13 heats", int'(heat_en), 1);
        strobe(15);
        chk("R4 done at 15", int'(done), 1);

        // R6: timeout after TO frames
        request();
        strobe(8);
        for (int k = 0; k < TO - 1; k++) strobe(9);
        chk("R6 heating before limit", int'(heat_en), 1);
        chk("R6 no timeout before limit", int'(timeout), 0);
        strobe(9);
        chk("R6 timeout", int'(timeout), 1);
        chk("R6 heat off", int'(heat_en), 0);
        chk("R6 busy low", int'(busy), 0);
        chk("R6 done low", int'(done), 0);

        // R6 boundary: target reached on the limiting strobe
        request();
        strobe(2);
        for (int k = 0; k < TO - 1; k++) strobe(3);
        strobe(4);
        chk("R6 target wins done", int'(done), 1);
        chk("R6 target wins timeout", int'(timeout), 0);

        // R7: nap during heating
        request();
        strobe(6);
        chk("R7 heating", int'(heat_en), 1);
        nap = 1'b1;
        #1;
        chk("R7 heat off same cycle", int'(heat_en), 0);
        @(negedge clk);
        chk("R7 idle", int'(busy), 0);
        request();
        chk("R7 req ignored in nap", int'(busy), 0);
        nap = 1'b0;
        @(negedge clk);

        // R7: nap clears done flag
        request();
        strobe(15);
        chk("R7 pre done", int'(done), 1);
        nap = 1'b1;
        @(negedge clk);
        nap = 1'b0;
        chk("R7 done cleared", int'(done), 0);
        chk("R7 sat cleared", int'(sat_done), 0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule